// File: doc/BRIEF.md
# Low-Power State Sequencer for an Embedded Keyboard Controller Core

This block decides when the clocks of a small keyboard-controller core may run. The instruction decoder raises a light-sleep request or a deep-sleep request. The light sleep freezes only the arithmetic unit. The timer and the interrupt logic keep running. The deep sleep also drops the oscillator enable, so every clock of the core stops. The sequencer runs on an always-on clock and watches for two wake sources: the core reset request and a host byte written into the input buffer.

When a light sleep ends, the core resumes in the next cycle. When a deep sleep ends, the oscillator is turned back on first. A programmable stabilisation count must then run out before any clock enable is released. In the cycle the core is released, the block gives a one-cycle resume pulse with a code for how to continue. The code says whether to call the input-buffer interrupt, run the next instruction, or restart from address zero. The host write that wakes the core is always passed on as a buffer-full set, so the byte is never lost.

Top module: `pdseq_top`

## Requirements
- R1: While `rst_n` is low and after it rises, `pd_state` is 00 (running), `alu_clk_en`, `tmr_clk_en` and `osc_en` are all 1, `resume_valid` is 0 and `resume_kind` is 00.
- R2: `halt_req` in the running state moves the block to `pd_state` 01 at the next edge. In that state `alu_clk_en` is 0 while `tmr_clk_en` and `osc_en` stay 1.
- R3: `stop_req` in the running state moves the block to `pd_state` 10 at the next edge, with all three enables at 0. When `stop_req` and `halt_req` arrive together, `stop_req` wins.
- R4: A `host_wr` in state 01 returns the block to state 00 at the next edge, with `resume_valid` high. `resume_kind` is 01 (call interrupt) if `ibf_ie` is 1 and 10 (next instruction) if it is 0.
- R5: A `core_rst` in a sleep state selects `resume_kind` 11 (restart at address 0). It takes priority over a `host_wr` in the same cycle.
- R6: A wake in state 10 moves the block to state 11 (oscillator warm-up), with `osc_en` 1 and the other two enables 0. The block stays there for exactly `STAB_CYCLES` cycles, counted by a 16-bit counter, and then returns to state 00 with `resume_valid` high.
- R7: For a deep-sleep wake, the resume code is fixed from the wake source and `ibf_ie` at the wake edge. A later change of `ibf_ie` has no effect. A `core_rst` during warm-up turns the code into 11 and does not change the warm-up length.
- R8: `ibf_set` follows `host_wr` in the same cycle in every state.
- R9: `halt_req` and `stop_req` are ignored outside the running state, and also when `core_rst` is high. A `host_wr` in the running state does not change the state.
- R10: `resume_valid` is a one-cycle pulse. It is given only on a return to state 00 from a sleep or warm-up state. At all other times `resume_kind` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | Light-sleep request from the decoder |
| stop_req | input | 1 | Deep-sleep request from the decoder |
| core_rst | input | 1 | Core reset request (wake source) |
| host_wr | input | 1 | Host byte written into the input buffer |
| ibf_ie | input | 1 | Input-buffer-full interrupt enable |
| alu_clk_en | output | 1 | Clock enable for the arithmetic unit |
| tmr_clk_en | output | 1 | Clock enable for timer and interrupt logic |
| osc_en | output | 1 | Oscillator enable |
| pd_state | output | 2 | 00 run, 01 light sleep, 10 deep sleep, 11 warm-up |
| resume_valid | output | 1 | One-cycle pulse when the core is released |
| resume_kind | output | 2 | 01 call interrupt, 10 next instruction, 11 restart, 00 none |
| ibf_set | output | 1 | Sets the input-buffer-full flag |

## Verification
The bench goes after these corner cases:
- A reset request and a host write in the same cycle. A design with the wrong priority would report an interrupt call instead of a restart.
- A sleep request raised together with a reset request, and sleep requests raised while already asleep. A design that does not guard these would drop clocks when it must not.
- The exact length of the warm-up. A counter that is off by one would release the enables a cycle early or late.
- An interrupt enable that changes after the deep-sleep wake, and a reset raised during warm-up. A design that samples the resume code at the wrong time would hand the core the wrong code.
- A host write that arrives while the oscillator is stopped. This write must still set the buffer-full flag.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    PD_RUN  = 2'b00,
    PD_SOFT = 2'b01,
    PD_HARD = 2'b10,
    PD_WARM = 2'b11
  } pd_state_e;

  typedef enum logic [1:0] {
    RK_NONE    = 2'b00,
    RK_CALL    = 2'b01,
    RK_NEXT    = 2'b10,
    RK_RESTART = 2'b11
  } resume_e;

  typedef struct packed {
    logic alu;
    logic tmr;
    logic osc;
  } gate_t;

  // Resume code chosen by the wake source; reset dominates.
  function automatic resume_e wake_kind(input logic rst_wake, input logic ie);
    if (rst_wake)  return RK_RESTART;
    else if (ie)   return RK_CALL;
    else           return RK_NEXT;
  endfunction

  // Clock enables per state.
  function automatic gate_t gates_for(input pd_state_e s);
    gate_t g;
    case (s)
      PD_RUN:  g = '{alu: 1'b1, tmr: 1'b1, osc: 1'b1};
      PD_SOFT: g = '{alu: 1'b0, tmr: 1'b1, osc: 1'b1};
      PD_HARD: g = '{alu: 1'b0, tmr: 1'b0, osc: 1'b0};
      default: g = '{alu: 1'b0, tmr: 1'b0, osc: 1'b1};
    endcase
    return g;
  endfunction

  // Sleep depth picked from the decoder requests; deep sleep wins.
  function automatic pd_state_e sleep_pick(input logic halt, input logic stop);
    if (stop)      return PD_HARD;
    else if (halt) return PD_SOFT;
    else           return PD_RUN;
  endfunction

endpackage

// File: rtl/pdseq_stab_cnt.sv
module pdseq_stab_cnt #(
  parameter int CNT_W       = 16,
  parameter int STAB_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(STAB_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (load)                   cnt_q <= LOAD_VAL;
    else if (run && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      halt_req,
  input  logic      stop_req,
  input  logic      core_rst,
  input  logic      host_wr,
  input  logic      ibf_ie,
  input  logic      stab_done,
  output pd_state_e state,
  output logic      cnt_load,
  output logic      wake_evt,
  output logic      resume_valid,
  output resume_e   resume_kind
);
  pd_state_e state_q, state_d;
  resume_e   pend_q, pend_d, fire_kind;
  logic      fire, valid_q;
  resume_e   kind_q;
  resume_e   kind_now;

  assign wake_evt = core_rst | host_wr;
  assign kind_now = wake_kind(core_rst, ibf_ie);

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    fire      = 1'b0;
    fire_kind = RK_NONE;
    cnt_load  = 1'b0;
    case (state_q)
      PD_RUN: begin
        if (!core_rst) state_d = sleep_pick(halt_req, stop_req);
      end
      PD_SOFT: begin
        if (wake_evt) begin
          state_d   = PD_RUN;
          fire      = 1'b1;
          fire_kind = kind_now;
        end
      end
      PD_HARD: begin
        if (wake_evt) begin
          state_d  = PD_WARM;
          pend_d   = kind_now;
          cnt_load = 1'b1;
        end
      end
      default: begin
        if (core_rst) pend_d = RK_RESTART;
        if (stab_done) begin
          state_d   = PD_RUN;
          fire      = 1'b1;
          fire_kind = core_rst ? RK_RESTART : pend_q;
          pend_d    = RK_NONE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PD_RUN;
      pend_q  <= RK_NONE;
      valid_q <= 1'b0;
      kind_q  <= RK_NONE;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      valid_q <= fire;
      kind_q  <= fire ? fire_kind : RK_NONE;
    end
  end

  assign state        = state_q;
  assign resume_valid = valid_q;
  assign resume_kind  = kind_q;
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int STAB_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       stop_req,
  input  logic       core_rst,
  input  logic       host_wr,
  input  logic       ibf_ie,
  output logic       alu_clk_en,
  output logic       tmr_clk_en,
  output logic       osc_en,
  output logic [1:0] pd_state,
  output logic       resume_valid,
  output logic [1:0] resume_kind,
  output logic       ibf_set
);
  pd_state_e state;
  resume_e   kind;
  gate_t     gates;
  logic      cnt_load, stab_expired, stab_done, wake_evt;

  pdseq_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_req     (halt_req),
    .stop_req     (stop_req),
    .core_rst     (core_rst),
    .host_wr      (host_wr),
    .ibf_ie       (ibf_ie),
    .stab_done    (stab_done),
    .state        (state),
    .cnt_load     (cnt_load),
    .wake_evt     (wake_evt),
    .resume_valid (resume_valid),
    .resume_kind  (kind)
  );

  pdseq_stab_cnt #(.CNT_W(CNT_W), .STAB_CYCLES(STAB_CYCLES)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cnt_load),
    .run     (state == PD_WARM),
    .expired (stab_expired)
  );

  assign stab_done  = stab_expired && (state == PD_WARM);
  assign gates      = gates_for(state);
  assign alu_clk_en = gates.alu;
  assign tmr_clk_en = gates.tmr;
  assign osc_en     = gates.osc;
  assign pd_state   = state;
  assign resume_kind = kind;
  assign ibf_set    = host_wr;
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk #(
  parameter int STAB_CYCLES = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       stop_req,
  input logic       core_rst,
  input logic       host_wr,
  input logic       wake_evt,
  input logic       alu_clk_en,
  input logic       tmr_clk_en,
  input logic       osc_en,
  input logic [1:0] pd_state,
  input logic       resume_valid,
  input logic [1:0] resume_kind
);
  int unsigned warm_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                warm_len <= 0;
    else if (pd_state == 2'b11) warm_len <= warm_len + 1;
    else                       warm_len <= 0;
  end

  a_r2_soft_gates: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b01 |-> (!alu_clk_en && tmr_clk_en && osc_en));

  a_r3_hard_gates: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b10 |-> (!alu_clk_en && !tmr_clk_en && !osc_en));

  a_r4_soft_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b01 && wake_evt) |=> (pd_state == 2'b00 && resume_valid));

  a_r5_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b01 && core_rst) |=> resume_kind == 2'b11);

  a_r6_warm_gates: assert property (@(posedge clk) disable iff (!rst_n)
    pd_state == 2'b11 |-> (osc_en && !alu_clk_en && !tmr_clk_en));

  a_r6_warm_len: assert property (@(posedge clk) disable iff (!rst_n)
    warm_len <= STAB_CYCLES);

  a_r9_no_sleep_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_state == 2'b00 && core_rst) |=> pd_state == 2'b00);

  a_r10_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resume_valid |=> !resume_valid);

  a_r10_kind_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !resume_valid |-> resume_kind == 2'b00);
endmodule

bind pdseq_top pdseq_chk #(.STAB_CYCLES(STAB_CYCLES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .halt_req     (halt_req),
  .stop_req     (stop_req),
  .core_rst     (core_rst),
  .host_wr      (host_wr),
  .wake_evt     (wake_evt),
  .alu_clk_en   (alu_clk_en),
  .tmr_clk_en   (tmr_clk_en),
  .osc_en       (osc_en),
  .pd_state     (pd_state),
  .resume_valid (resume_valid),
  .resume_kind  (resume_kind)
);

// File: tb/tb_pdseq_top.sv
`timescale 1ns/1ps
module tb_pdseq_top;
  localparam int S = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, stop_req = 0, core_rst = 0, host_wr = 0, ibf_ie = 0;
  logic alu_clk_en, tmr_clk_en, osc_en, resume_valid, ibf_set;
  logic [1:0] pd_state, resume_kind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pdseq_top #(.CNT_W(16), .STAB_CYCLES(S)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .stop_req(stop_req),
    .core_rst(core_rst), .host_wr(host_wr), .ibf_ie(ibf_ie),
    .alu_clk_en(alu_clk_en), .tmr_clk_en(tmr_clk_en), .osc_en(osc_en),
    .pd_state(pd_state), .resume_valid(resume_valid),
    .resume_kind(resume_kind), .ibf_set(ibf_set)
  );

  // vector: {deep, reset_wake, ie, expected_kind[1:0]}
  localparam logic [4:0] VEC [8] = '{
    5'b0_0_0_10, 5'b0_0_1_01, 5'b0_1_0_11, 5'b0_1_1_11,
    5'b1_0_0_10, 5'b1_0_1_01, 5'b1_1_0_11, 5'b1_1_1_11
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_state(input logic [1:0] exp, input string req);
    chk(pd_state == exp, req, pd_state, exp);
    case (exp)
      2'b00: chk({alu_clk_en, tmr_clk_en, osc_en} == 3'b111, req, {alu_clk_en, tmr_clk_en, osc_en}, 7);
      2'b01: chk({alu_clk_en, tmr_clk_en, osc_en} == 3'b011, req, {alu_clk_en, tmr_clk_en, osc_en}, 3);
      2'b10: chk({alu_clk_en, tmr_clk_en, osc_en} == 3'b000, req, {alu_clk_en, tmr_clk_en, osc_en}, 0);
      default: chk({alu_clk_en, tmr_clk_en, osc_en} == 3'b001, req, {alu_clk_en, tmr_clk_en, osc_en}, 1);
    endcase
  endtask

  task automatic chk_resume(input logic [1:0] exp, input string req);
    chk(resume_valid == 1'b1, req, resume_valid, 1);
    chk(resume_kind == exp, req, resume_kind, exp);
    step();
    chk(resume_valid == 1'b0, "R10", resume_valid, 0);
    chk(resume_kind == 2'b00, "R10", resume_kind, 0);
  endtask

  // remaining warm-up cycles after the wake sample, then release
  task automatic ride_warm(input string req);
    for (int i = 1; i < S; i++) begin
      step();
      chk_state(2'b11, req);
    end
    step();
    chk_state(2'b00, req);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk_state(2'b00, "R1");
    chk(resume_valid == 0 && resume_kind == 0, "R1", resume_kind, 0);
    step();
    rst_n = 1'b1;
    step();
    chk_state(2'b00, "R1");

    // table walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      logic deep, rw, ie;
      logic [1:0] ek;
      {deep, rw, ie, ek} = VEC[v];
      if (deep) stop_req = 1; else halt_req = 1;
      step();
      halt_req = 0; stop_req = 0;
      chk_state(deep ? 2'b10 : 2'b01, deep ? "R3" : "R2");
      ibf_ie = ie;
      if (rw) core_rst = 1; else host_wr = 1;
      step();
      core_rst = 0; host_wr = 0; ibf_ie = 0;
      if (deep) begin
        chk_state(2'b11, "R6");
        ride_warm("R6");
        chk_resume(ek, rw ? "R5" : "R6");
      end else begin
        chk_state(2'b00, "R4");
        chk_resume(ek, rw ? "R5" : "R4");
      end
    end

    // R5 reset and host write in the same cycle
    halt_req = 1; step(); halt_req = 0;
    ibf_ie = 1; core_rst = 1; host_wr = 1;
    step();
    core_rst = 0; host_wr = 0; ibf_ie = 0;
    chk_state(2'b00, "R5");
    chk_resume(2'b11, "R5");

    // R3 both requests together -> deep; R8 write while oscillator off
    halt_req = 1; stop_req = 1; step(); halt_req = 0; stop_req = 0;
    chk_state(2'b10, "R3");
    host_wr = 1; ibf_ie = 0;
    #1 chk(ibf_set == 1'b1, "R8", ibf_set, 1);
    step();
    host_wr = 0;
    #1 chk(ibf_set == 1'b0, "R8", ibf_set, 0);
    // R7 enable raised after the wake has no effect
    ibf_ie = 1;
    chk_state(2'b11, "R7");
    ride_warm("R7");
    chk_resume(2'b10, "R7");
    ibf_ie = 0;

    // R7 reset during warm-up turns the code into restart, same length
    stop_req = 1; step(); stop_req = 0;
    ibf_ie = 1; host_wr = 1; step(); host_wr = 0;
    chk_state(2'b11, "R7");
    step(); chk_state(2'b11, "R7");
    core_rst = 1; step(); core_rst = 0;
    for (int i = 3; i < S; i++) begin
      chk_state(2'b11, "R7");
      step();
    end
    chk_state(2'b11, "R7");
    step();
    chk_state(2'b00, "R7");
    chk_resume(2'b11, "R7");
    ibf_ie = 0;

    // R9 sleep requests with reset in the running state are ignored
    halt_req = 1; stop_req = 1; core_rst = 1; step();
    halt_req = 0; stop_req = 0; core_rst = 0;
    chk_state(2'b00, "R9");
    chk(resume_valid == 0, "R10", resume_valid, 0);
    // R9 host write while running leaves state alone; R8 passes through
    host_wr = 1;
    #1 chk(ibf_set == 1'b1, "R8", ibf_set, 1);
    step(); host_wr = 0;
    chk_state(2'b00, "R9");
    chk(resume_valid == 0, "R10", resume_valid, 0);
    // R9 deep request while in light sleep is ignored
    halt_req = 1; step(); halt_req = 0;
    stop_req = 1; step(); stop_req = 0;
    chk_state(2'b01, "R9");
    host_wr = 1; step(); host_wr = 0;
    chk_resume(2'b10, "R4");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule